// File: doc/BRIEF.md
# Root Port Request Router

This block is the request-steering stage of a PCI Express root port. It works on whole transactions, not on link symbols. Each cycle it can take one request from the host side. The request is a type-0 configuration access, a type-1 configuration access or a memory access. One clock later the block gives exactly one outcome:

- the request is handed to the port's own configuration logic;
- it is sent downstream unchanged;
- it is sent downstream after being rewritten from type-1 to type-0;
- it is answered at once with an Unsupported Request error completion.

Configuration requests are steered by the programmed secondary and subordinate bus numbers. Memory requests are steered by two address windows, one non-prefetchable and one prefetchable. A link-status input blocks all downstream traffic while the link is down.

Completions that come back from downstream pass through a small relay stage. That stage replaces the payload of a failed configuration read with all ones, so host software sees the usual value for an absent function. Error completions that the router makes itself carry a completer ID built from the port's own bus, device and function numbers.

Top module: `rr_router`

## Requirements
- R1: A type-1 configuration request (req_kind 2'b01) whose bus is above sec_bus and at or below sub_bus is sent downstream one cycle later, with the link up, as type-1 (dn_kind 2'b01) with bus, device, function, address and direction unchanged.
- R2: A type-1 request whose bus equals sec_bus and whose device is 0 is sent downstream, with the link up, as type-0 (dn_kind 2'b00) with its other fields unchanged.
- R3: A type-0 configuration request (req_kind 2'b00) is given to the port itself: loc_valid rises one cycle later. No downstream request and no error completion is made. At most one of loc_valid, dn_valid and hc_valid is high in any cycle.
- R4: A type-1 read to bus sec_bus with a nonzero device number is not forwarded. It gets an error completion with hc_has_data high and hc_data all ones.
- R5: While link_up is low, no request is sent downstream. A type-1 configuration read that would have been forwarded or converted gets an error completion with all-ones data instead.
- R6: A downstream completion is relayed one cycle later. When it is a configuration completion (dn_cpl_cfg high) with Unsupported Request status (dn_cpl_ur high), rl_data is all ones. In every other case rl_data equals dn_cpl_data. rl_ur follows dn_cpl_ur.
- R7: A memory request (req_kind 2'b10) whose address lies between base and limit, both inclusive, of an enabled window is sent downstream as memory (dn_kind 2'b10). Any other memory request gets an error completion with hc_has_data low.
- R8: A window whose limit is below its base is disabled and matches no address.
- R9: A type-1 request whose bus is below sec_bus or above sub_bus gets an error completion and is not forwarded.
- R10: A configuration write that ends in an error gets an error completion with hc_has_data low and hc_data zero.
- R11: hc_cpl_id on every error completion equals {own_bus, own_dev, own_fn}.
- R12: After reset, loc_valid, dn_valid, hc_valid and rl_valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_kind | input | 2 | 00 type-0 cfg, 01 type-1 cfg, 10 memory |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bus | input | BUS_W | Target bus number |
| req_dev | input | DEV_W | Target device number |
| req_fn | input | FN_W | Target function number |
| req_addr | input | ADDR_W | Register offset or memory address |
| own_bus | input | BUS_W | Port's own bus number |
| own_dev | input | DEV_W | Port's own device number |
| own_fn | input | FN_W | Port's own function number |
| sec_bus | input | BUS_W | Secondary bus number |
| sub_bus | input | BUS_W | Subordinate bus number |
| np_base | input | ADDR_W | Non-prefetchable window base |
| np_limit | input | ADDR_W | Non-prefetchable window limit |
| pf_base | input | ADDR_W | Prefetchable window base |
| pf_limit | input | ADDR_W | Prefetchable window limit |
| link_up | input | 1 | Downstream link is active |
| dn_cpl_valid | input | 1 | Completion arriving from downstream |
| dn_cpl_cfg | input | 1 | That completion answers a configuration read |
| dn_cpl_ur | input | 1 | That completion has Unsupported Request status |
| dn_cpl_data | input | DATA_W | That completion's payload |
| loc_valid | output | 1 | Request handed to port's own registers |
| loc_write | output | 1 | Direction of the local request |
| loc_addr | output | ADDR_W | Register offset of the local request |
| dn_valid | output | 1 | Request sent downstream |
| dn_kind | output | 2 | Kind of the downstream request |
| dn_write | output | 1 | Direction of the downstream request |
| dn_bus | output | BUS_W | Downstream target bus |
| dn_dev | output | DEV_W | Downstream target device |
| dn_fn | output | FN_W | Downstream target function |
| dn_addr | output | ADDR_W | Downstream address or offset |
| hc_valid | output | 1 | Error (Unsupported Request) completion to host |
| hc_has_data | output | 1 | Error completion carries a payload |
| hc_data | output | DATA_W | Error completion payload |
| hc_cpl_id | output | BUS_W+DEV_W+FN_W | Completer ID of the error completion |
| rl_valid | output | 1 | Relayed downstream completion to host |
| rl_ur | output | 1 | Relayed completion status is Unsupported Request |
| rl_data | output | DATA_W | Relayed completion payload |

## Verification
A wrong range compare or a wrong window compare shows up in the cycle after the request. The wrong one of loc_valid, dn_valid and hc_valid rises, or dn_kind carries the wrong type. A stuck link gate or a stuck conversion flag shows up the same way, one cycle after any request to the affected bus, device or address. The sweeps cover every bus across and beyond the secondary-to-subordinate range. They also walk addresses across both edges of each window, with a window enabled and disabled. So an off-by-one compare is caught on the first request at the boundary it misplaces.

// File: rtl/rr_pkg.sv
package rr_pkg;
   typedef enum logic [1:0] {
      KIND_CFG0 = 2'b00,
      KIND_CFG1 = 2'b01,
      KIND_MEM  = 2'b10,
      KIND_RSVD = 2'b11
   } req_kind_e;

   typedef enum logic [1:0] {
      ACT_LOCAL = 2'b00,
      ACT_FWD   = 2'b01,
      ACT_CONV  = 2'b10,
      ACT_ERR   = 2'b11
   } route_act_e;
endpackage

// File: rtl/rr_window_match.sv
module rr_window_match #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] limit,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   logic enabled;
   always_comb begin
      // R8: a window whose limit is below its base is switched off
      enabled = (limit >= base);
      hit     = enabled && (addr >= base) && (addr <= limit);
   end
endmodule

// File: rtl/rr_route_decide.sv
module rr_route_decide #(
   parameter int BUS_W = 8,
   parameter int DEV_W = 5
) (
   input  rr_pkg::req_kind_e  kind,
   input  logic [BUS_W-1:0]   bus,
   input  logic [DEV_W-1:0]   dev,
   input  logic [BUS_W-1:0]   sec_bus,
   input  logic [BUS_W-1:0]   sub_bus,
   input  logic               mem_hit,
   input  logic               link_up,
   output rr_pkg::route_act_e act
);
   import rr_pkg::*;

   logic on_sec, below_port;
   always_comb begin
      on_sec     = (bus == sec_bus);
      below_port = (bus > sec_bus) && (bus <= sub_bus);
      act        = ACT_ERR;
      unique case (kind)
         KIND_CFG0: act = ACT_LOCAL;
         KIND_CFG1: begin
            if (on_sec)
               // only device 0 can exist on the link below the port
               act = (link_up && (dev == '0)) ? ACT_CONV : ACT_ERR;
            else if (below_port)
               act = link_up ? ACT_FWD : ACT_ERR;
            else
               act = ACT_ERR;
         end
         KIND_MEM:  act = (mem_hit && link_up) ? ACT_FWD : ACT_ERR;
         default:   act = ACT_ERR;
      endcase
   end
endmodule

// File: rtl/rr_cpl_relay.sv
module rr_cpl_relay #(
   parameter int DATA_W  = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_cfg,
   input  logic              in_ur,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic              out_ur,
   output logic [DATA_W-1:0] out_data
);
   logic [DATA_W-1:0] shaped;
   always_comb shaped = (in_cfg && in_ur) ? {DATA_W{1'b1}} : in_data;

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               out_ur    <= 1'b0;
               out_data  <= '0;
            end else begin
               out_valid <= in_valid;
               out_ur    <= in_valid && in_ur;
               out_data  <= in_valid ? shaped : '0;
            end
         end
      end else begin : g_comb
         always_comb begin
            out_valid = in_valid;
            out_ur    = in_valid && in_ur;
            out_data  = in_valid ? shaped : '0;
         end
      end
   endgenerate
endmodule

// File: rtl/rr_router.sv
module rr_router #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int BUS_W     = 8,
   parameter int DEV_W     = 5,
   parameter int FN_W      = 3,
   parameter bit RELAY_REG = 1'b1,
   localparam int ID_W     = BUS_W + DEV_W + FN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic              req_write,
   input  logic [BUS_W-1:0]  req_bus,
   input  logic [DEV_W-1:0]  req_dev,
   input  logic [FN_W-1:0]   req_fn,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [BUS_W-1:0]  own_bus,
   input  logic [DEV_W-1:0]  own_dev,
   input  logic [FN_W-1:0]   own_fn,
   input  logic [BUS_W-1:0]  sec_bus,
   input  logic [BUS_W-1:0]  sub_bus,
   input  logic [ADDR_W-1:0] np_base,
   input  logic [ADDR_W-1:0] np_limit,
   input  logic [ADDR_W-1:0] pf_base,
   input  logic [ADDR_W-1:0] pf_limit,
   input  logic              link_up,
   input  logic              dn_cpl_valid,
   input  logic              dn_cpl_cfg,
   input  logic              dn_cpl_ur,
   input  logic [DATA_W-1:0] dn_cpl_data,
   output logic              loc_valid,
   output logic              loc_write,
   output logic [ADDR_W-1:0] loc_addr,
   output logic              dn_valid,
   output logic [1:0]        dn_kind,
   output logic              dn_write,
   output logic [BUS_W-1:0]  dn_bus,
   output logic [DEV_W-1:0]  dn_dev,
   output logic [FN_W-1:0]   dn_fn,
   output logic [ADDR_W-1:0] dn_addr,
   output logic              hc_valid,
   output logic              hc_has_data,
   output logic [DATA_W-1:0] hc_data,
   output logic [ID_W-1:0]   hc_cpl_id,
   output logic              rl_valid,
   output logic              rl_ur,
   output logic [DATA_W-1:0] rl_data
);
   import rr_pkg::*;

   localparam int NWIN = 2;

   generate
      if (BUS_W < 1 || BUS_W > 8) begin : g_bad_bus
         $error("rr_router: BUS_W must be 1..8");
      end
      if (DEV_W != 5) begin : g_bad_dev
         $error("rr_router: DEV_W must be 5");
      end
      if (FN_W != 3) begin : g_bad_fn
         $error("rr_router: FN_W must be 3");
      end
      if (ADDR_W < 12) begin : g_bad_addr
         $error("rr_router: ADDR_W must be at least 12");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("rr_router: DATA_W must be at least 8");
      end
   endgenerate

   // window 0 non-prefetchable, window 1 prefetchable
   logic [NWIN-1:0][ADDR_W-1:0] win_base, win_limit;
   logic [NWIN-1:0]             win_hit;
   always_comb begin
      win_base[0]  = np_base;
      win_limit[0] = np_limit;
      win_base[1]  = pf_base;
      win_limit[1] = pf_limit;
   end

   generate
      for (genvar w = 0; w < NWIN; w++) begin : g_win
         rr_window_match #(.ADDR_W(ADDR_W)) u_win (
            .base  (win_base[w]),
            .limit (win_limit[w]),
            .addr  (req_addr),
            .hit   (win_hit[w])
         );
      end
   endgenerate

   route_act_e act;
   req_kind_e  kind_in;
   always_comb kind_in = req_kind_e'(req_kind);

   rr_route_decide #(.BUS_W(BUS_W), .DEV_W(DEV_W)) u_decide (
      .kind    (kind_in),
      .bus     (req_bus),
      .dev     (req_dev),
      .sec_bus (sec_bus),
      .sub_bus (sub_bus),
      .mem_hit (|win_hit),
      .link_up (link_up),
      .act     (act)
   );

   logic is_cfg_read;
   always_comb is_cfg_read = !req_write &&
                             ((kind_in == KIND_CFG0) || (kind_in == KIND_CFG1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         loc_valid   <= 1'b0;
         loc_write   <= 1'b0;
         loc_addr    <= '0;
         dn_valid    <= 1'b0;
         dn_kind     <= 2'b00;
         dn_write    <= 1'b0;
         dn_bus      <= '0;
         dn_dev      <= '0;
         dn_fn       <= '0;
         dn_addr     <= '0;
         hc_valid    <= 1'b0;
         hc_has_data <= 1'b0;
         hc_data     <= '0;
         hc_cpl_id   <= '0;
      end else begin
         loc_valid <= req_valid && (act == ACT_LOCAL);
         loc_write <= req_write;
         loc_addr  <= req_addr;

         dn_valid  <= req_valid && ((act == ACT_FWD) || (act == ACT_CONV));
         dn_kind   <= (act == ACT_CONV) ? KIND_CFG0 : req_kind;
         dn_write  <= req_write;
         dn_bus    <= req_bus;
         dn_dev    <= req_dev;
         dn_fn     <= req_fn;
         dn_addr   <= req_addr;

         hc_valid    <= req_valid && (act == ACT_ERR);
         hc_has_data <= req_valid && (act == ACT_ERR) && is_cfg_read;
         hc_data     <= (req_valid && (act == ACT_ERR) && is_cfg_read) ?
                        {DATA_W{1'b1}} : '0;
         hc_cpl_id   <= {own_bus, own_dev, own_fn};
      end
   end

   rr_cpl_relay #(.DATA_W(DATA_W), .REG_OUT(RELAY_REG)) u_relay (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (dn_cpl_valid),
      .in_cfg    (dn_cpl_cfg),
      .in_ur     (dn_cpl_ur),
      .in_data   (dn_cpl_data),
      .out_valid (rl_valid),
      .out_ur    (rl_ur),
      .out_data  (rl_data)
   );
endmodule

// File: rtl/rr_router_chk.sv
module rr_router_chk #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int BUS_W     = 8,
   parameter int DEV_W     = 5,
   parameter int FN_W      = 3,
   parameter bit RELAY_REG = 1'b1
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [1:0]                  req_kind,
   input logic                        req_write,
   input logic [BUS_W-1:0]            req_bus,
   input logic [BUS_W-1:0]            sec_bus,
   input logic [BUS_W-1:0]            sub_bus,
   input logic [BUS_W-1:0]            own_bus,
   input logic [DEV_W-1:0]            own_dev,
   input logic [FN_W-1:0]             own_fn,
   input logic                        link_up,
   input logic                        dn_cpl_cfg,
   input logic                        dn_cpl_ur,
   input logic                        loc_valid,
   input logic                        dn_valid,
   input logic                        hc_valid,
   input logic                        hc_has_data,
   input logic [DATA_W-1:0]           hc_data,
   input logic [BUS_W+DEV_W+FN_W-1:0] hc_cpl_id,
   input logic                        rl_valid,
   input logic [DATA_W-1:0]           rl_data
);
   assert_one_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({loc_valid, dn_valid, hc_valid}));

   assert_no_fwd_link_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |-> $past(link_up));

   assert_err_read_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hc_valid && hc_has_data) |-> (&hc_data));

   assert_err_write_nodata_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (hc_valid && $past(req_write)) |-> !hc_has_data);

   assert_cpl_id_R11: assert property (@(posedge clk) disable iff (!rst_n)
      hc_valid |-> (hc_cpl_id == $past({own_bus, own_dev, own_fn})));

   assert_type1_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && ($past(req_kind) == 2'b01)) |->
         (($past(req_bus) >= $past(sec_bus)) && ($past(req_bus) <= $past(sub_bus))));

   generate
      if (RELAY_REG) begin : g_relay_chk
         assert_relay_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (rl_valid && $past(dn_cpl_cfg && dn_cpl_ur)) |-> (&rl_data));
      end
   endgenerate
endmodule

bind rr_router rr_router_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W),
   .DEV_W(DEV_W), .FN_W(FN_W), .RELAY_REG(RELAY_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_kind(req_kind), .req_write(req_write),
   .req_bus(req_bus), .sec_bus(sec_bus), .sub_bus(sub_bus),
   .own_bus(own_bus), .own_dev(own_dev), .own_fn(own_fn),
   .link_up(link_up), .dn_cpl_cfg(dn_cpl_cfg), .dn_cpl_ur(dn_cpl_ur),
   .loc_valid(loc_valid), .dn_valid(dn_valid), .hc_valid(hc_valid),
   .hc_has_data(hc_has_data), .hc_data(hc_data), .hc_cpl_id(hc_cpl_id),
   .rl_valid(rl_valid), .rl_data(rl_data)
);

// File: tb/test_rr_router.sv
`timescale 1ns/1ps
module test_rr_router;
   localparam int AW = 32, DW = 32, BW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_kind = 2'b00;
   logic          req_write = 1'b0;
   logic [BW-1:0] req_bus = '0;
   logic [4:0]    req_dev = '0;
   logic [2:0]    req_fn = '0;
   logic [AW-1:0] req_addr = '0;
   logic [BW-1:0] own_bus = 8'h00;
   logic [4:0]    own_dev = 5'd3;
   logic [2:0]    own_fn = 3'd1;
   logic [BW-1:0] sec_bus = 8'd4;
   logic [BW-1:0] sub_bus = 8'd9;
   logic [AW-1:0] np_base = 32'h1000, np_limit = 32'h1FFF;
   logic [AW-1:0] pf_base = 32'h8000, pf_limit = 32'h8FFF;
   logic          link_up = 1'b1;
   logic          dn_cpl_valid = 1'b0, dn_cpl_cfg = 1'b0, dn_cpl_ur = 1'b0;
   logic [DW-1:0] dn_cpl_data = '0;

   logic          loc_valid, loc_write;
   logic [AW-1:0] loc_addr;
   logic          dn_valid, dn_write;
   logic [1:0]    dn_kind;
   logic [BW-1:0] dn_bus;
   logic [4:0]    dn_dev;
   logic [2:0]    dn_fn;
   logic [AW-1:0] dn_addr;
   logic          hc_valid, hc_has_data;
   logic [DW-1:0] hc_data;
   logic [15:0]   hc_cpl_id;
   logic          rl_valid, rl_ur;
   logic [DW-1:0] rl_data;

   int compared = 0;
   int mismatched = 0;

   always #2.5 clk = ~clk;

   rr_router i_rr_router (
      .clk, .rst_n, .req_valid, .req_kind, .req_write, .req_bus, .req_dev,
      .req_fn, .req_addr, .own_bus, .own_dev, .own_fn, .sec_bus, .sub_bus,
      .np_base, .np_limit, .pf_base, .pf_limit, .link_up, .dn_cpl_valid,
      .dn_cpl_cfg, .dn_cpl_ur, .dn_cpl_data, .loc_valid, .loc_write, .loc_addr,
      .dn_valid, .dn_kind, .dn_write, .dn_bus, .dn_dev, .dn_fn, .dn_addr,
      .hc_valid, .hc_has_data, .hc_data, .hc_cpl_id, .rl_valid, .rl_ur, .rl_data
   );

   task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic win_hit(input logic [AW-1:0] b, input logic [AW-1:0] l,
                                    input logic [AW-1:0] a);
      return (l >= b) && (a >= b) && (a <= l);
   endfunction

   // expected outcome: 0 local, 1 downstream, 2 error completion
   task automatic send(input logic [1:0] kind, input logic wr, input int bus,
                       input int dev, input logic [AW-1:0] addr);
      int outcome;
      logic [1:0] ekind;
      string tag;
      outcome = 2;
      ekind = kind;
      tag = "R9";
      if (kind == 2'b00) begin
         outcome = 0; tag = "R3";
      end else if (kind == 2'b01) begin
         if (bus == int'(sec_bus)) begin
            if (!link_up) tag = "R5";
            else if (dev != 0) tag = "R4";
            else begin outcome = 1; ekind = 2'b00; tag = "R2"; end
         end else if (bus > int'(sec_bus) && bus <= int'(sub_bus)) begin
            if (link_up) begin outcome = 1; tag = "R1"; end
            else tag = "R5";
         end
         if (outcome == 2 && wr) tag = "R10";
      end else begin
         tag = "R7";
         if (win_hit(np_base, np_limit, addr) || win_hit(pf_base, pf_limit, addr))
            outcome = link_up ? 1 : 2;
         if (pf_limit < pf_base) tag = "R8";
      end
      @(negedge clk);
      req_valid = 1'b1; req_kind = kind; req_write = wr;
      req_bus = BW'(bus); req_dev = 5'(dev); req_fn = 3'd2; req_addr = addr;
      @(negedge clk);
      check(tag, {loc_valid, dn_valid, hc_valid},
            {outcome == 0, outcome == 1, outcome == 2});
      if (outcome == 1)
         check(tag, {dn_kind, dn_write, dn_bus, dn_dev, dn_fn, dn_addr},
               {ekind, wr, BW'(bus), 5'(dev), 3'd2, addr});
      if (outcome == 0)
         check(tag, {loc_write, loc_addr}, {wr, addr});
      if (outcome == 2) begin
         logic hd;
         hd = !wr && (kind != 2'b10);
         check(tag, {hc_has_data, hc_data}, {hd, hd ? {DW{1'b1}} : {DW{1'b0}}});
         check("R11", {112'd0, hc_cpl_id}, {112'd0, own_bus, own_dev, own_fn});
      end
      req_valid = 1'b0;
   endtask

   task automatic relay(input logic cfg, input logic ur, input logic [DW-1:0] d);
      @(negedge clk);
      dn_cpl_valid = 1'b1; dn_cpl_cfg = cfg; dn_cpl_ur = ur; dn_cpl_data = d;
      @(negedge clk);
      check("R6", {rl_valid, rl_ur, rl_data},
            {1'b1, ur, (cfg && ur) ? {DW{1'b1}} : d});
      dn_cpl_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R12", {loc_valid, dn_valid, hc_valid, rl_valid}, 4'b0000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12", {loc_valid, dn_valid, hc_valid, rl_valid}, 4'b0000);

      for (int lk = 1; lk >= 0; lk--) begin
         link_up = lk[0];
         for (int b = 0; b < 16; b++)
            for (int d = 0; d < 4; d += 3)
               for (int w = 0; w < 2; w++)
                  send(2'b01, w[0], b, d, 32'h0000_0010);
         send(2'b00, 1'b0, 0, 0, 32'h0000_0004);
         send(2'b00, 1'b1, 0, 0, 32'h0000_0018);
      end
      link_up = 1'b1;

      for (int pass = 0; pass < 3; pass++) begin
         if (pass == 1) begin pf_base = 32'h9000; pf_limit = 32'h8000; end
         if (pass == 2) begin pf_base = 32'h8000; pf_limit = 32'h8FFF; link_up = 1'b0; end
         for (int i = 0; i < 48; i++) send(2'b10, i[0], 0, 0, AW'(i * 32'h400));
         send(2'b10, 1'b0, 0, 0, 32'h0FFF);
         send(2'b10, 1'b0, 0, 0, 32'h1FFF);
         send(2'b10, 1'b0, 0, 0, 32'h2000);
         send(2'b10, 1'b1, 0, 0, 32'h7FFF);
         send(2'b10, 1'b0, 0, 0, 32'h8FFF);
         send(2'b10, 1'b0, 0, 0, 32'h9000);
      end
      link_up = 1'b1;

      relay(1'b1, 1'b1, 32'h1234_5678);
      relay(1'b1, 1'b0, 32'hCAFE_0001);
      relay(1'b0, 1'b1, 32'h0000_00A5);
      relay(1'b0, 1'b0, 32'h5A5A_5A5A);
      @(negedge clk);
      check("R6", {127'd0, rl_valid}, 128'd0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule